// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the device-side pointers for three descriptor rings that live in host memory. The request ring is consumed by the device. The completion ring and the message ring are produced into by the device. Each ring lies across a small table of page frame numbers that need not be contiguous. When a ring is set up, the block latches its page table and derives an index mask from the ring's size. The pointers are free-running 32-bit counters. They are masked only when a slot is formed, so a flush always reports the full unmasked count.

A requester drives one operation per cycle on a simple request/response interface: pop, flush or setup, aimed at one ring. Each operation carries the host-side producer and consumer indices that the requester has already read from memory. One cycle later the block returns the result:
- for a pop, the physical address of the descriptor slot;
- for a flush, the index value to publish;
- for a setup, the ring-size exponent to publish;
- a flag for an empty or full ring, or for an illegal setup.

The memory accesses themselves are done elsewhere.

Top module: `ring_idx_mgr`

## Requirements
- R1: After reset, rspValid is 0, and a flush of any ring reports index 0.
- R2: A setup (opCode 2) with a page count from 1 to MAX_PAGES does three things. It latches the first count entries of setupPfns (entry i at bits i*PFN_W), and it sets the ring pointer to 0. It also returns rspIdx 0 and rspLog2 = k, where k is the bit length of (count × entries-per-page − 1). The ring mask becomes 2^k − 1.
- R3: A setup with a page count of 0 or above MAX_PAGES returns rspSetupErr 1, rspLog2 0 and rspIdx equal to the unchanged pointer. The ring's mask, page table and pointer are left as they were.
- R4: A successful pop (opCode 0) returns the slot address. With slot = pointer AND mask, the address is (pageTable[slot / entries-per-page] << PAGE_SHIFT) + (slot mod entries-per-page) × descriptor size.
- R5: A pop of the request ring (opRing 0) when hostProd equals the consumed pointer returns rspEmpty 1 and address 0, and leaves the pointer unchanged.
- R6: Each successful pop increments the pointer without masking and returns the new pointer in rspIdx. The slot index wraps through the mask while the pointer keeps counting.
- R7: A pop of the completion ring (opRing 1) never reports empty, whatever the host indices are.
- R8: A pop of the message ring (opRing 2) succeeds only when (hostProd − hostCons) mod 2^32 is less than mask + 1. Otherwise it returns rspEmpty 1 and address 0, and the pointer is unchanged.
- R9: A flush (opCode 1) returns the ring's current pointer in rspIdx, with address 0 and no flags.
- R10: While cleanup is high, the block zeroes every mask, pointer and page table entry in one cycle, and any operation in that cycle gives no response.
- R11: A valid operation produces rspValid high exactly one cycle later. opRing 3 or opCode 3 produces no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cleanup | input | 1 | Synchronous clear of all ring state |
| opValid | input | 1 | Operation request strobe |
| opCode | input | 2 | 0 pop, 1 flush, 2 setup, 3 none |
| opRing | input | 2 | 0 request, 1 completion, 2 message, 3 none |
| setupCount | input | CNT_W (3) | Page count for a setup |
| setupPfns | input | MAX_PAGES*PFN_W (80) | Page frame numbers, entry i at bits i*PFN_W |
| hostProd | input | IDX_W (32) | Host producer index as read by the requester |
| hostCons | input | IDX_W (32) | Host consumer index as read by the requester |
| rspValid | output | 1 | Response strobe, one cycle after the operation |
| rspEmpty | output | 1 | Request ring empty or message ring full |
| rspSetupErr | output | 1 | Setup page count out of range |
| rspAddr | output | ADDR_W (32) | Descriptor slot address of a pop |
| rspIdx | output | IDX_W (32) | Pointer after the operation |
| rspLog2 | output | 6 | Ring-size exponent k from a setup |

## Verification
The bench keeps MAX_PAGES at 4, the page frame width at 20 bits and the page shift at 12. It reduces the number of entries per page to 4 for the request ring and to 2 for the completion and message rings. With these small rings, a few pops are enough to cross a page boundary, wrap the slot through the mask while the pointer keeps counting, and fill the message ring. A three-page request ring gives a size that is not a power of two, so the rounding of the mask can be checked. The message room check is also driven with host indices that straddle the 32-bit wrap.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;

  localparam int NUM_RINGS = 3;

  typedef enum logic [1:0] {
    OP_POP   = 2'd0,
    OP_FLUSH = 2'd1,
    OP_SETUP = 2'd2,
    OP_NONE  = 2'd3
  } opcode_e;

  // Strobes from control to the per-ring datapaths
  typedef struct packed {
    logic [NUM_RINGS-1:0] setupStb;
    logic [NUM_RINGS-1:0] popStb;
    logic                 clearAll;
  } ring_strobe_t;

  // Position of the highest set bit plus one; 0 for a zero input
  function automatic int unsigned bitLen(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ring_page_path.sv
module ring_page_path
  import ring_idx_pkg::*;
#(
  parameter int MAX_PAGES  = 4,
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 32,
  parameter int EPP_LOG2   = 5,
  parameter int DESC_LOG2  = 7,
  parameter int CNT_W      = 3,
  parameter int ADDR_W     = 32,
  parameter int LOG2_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clearAll,
  input  logic                       setupStb,
  input  logic                       popStb,
  input  logic [CNT_W-1:0]           setupCount,
  input  logic [MAX_PAGES*PFN_W-1:0] setupPfns,
  output logic [IDX_W-1:0]           ptr,
  output logic [IDX_W-1:0]           mask,
  output logic [ADDR_W-1:0]          slotAddr,
  output logic [LOG2_W-1:0]          setupLog2
);

  localparam int PG_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam logic [IDX_W-1:0] IN_PAGE_MASK = IDX_W'((64'd1 << EPP_LOG2) - 64'd1);

  logic [PFN_W-1:0]  pageTab [MAX_PAGES];
  logic [IDX_W-1:0]  ptrQ, maskQ, slot, ringSize, newMask;
  logic [PG_W-1:0]   pageSel;
  logic [LOG2_W-1:0] kVal;

  always_comb begin
    ringSize = IDX_W'(setupCount) << EPP_LOG2;
    kVal     = LOG2_W'(bitLen(32'(ringSize - 1'b1)));
    newMask  = (int'(kVal) >= IDX_W) ? '1 : ((IDX_W'(1) << kVal) - 1'b1);
    slot     = ptrQ & maskQ;
    pageSel  = PG_W'(slot >> EPP_LOG2);
    slotAddr = (ADDR_W'(pageTab[pageSel]) << PAGE_SHIFT)
             + (ADDR_W'(slot & IN_PAGE_MASK) << DESC_LOG2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ  <= '0;
      maskQ <= '0;
      for (int i = 0; i < MAX_PAGES; i++) pageTab[i] <= '0;
    end else if (clearAll) begin
      ptrQ  <= '0;
      maskQ <= '0;
      for (int i = 0; i < MAX_PAGES; i++) pageTab[i] <= '0;
    end else if (setupStb) begin
      ptrQ  <= '0;
      maskQ <= newMask;
      for (int i = 0; i < MAX_PAGES; i++) begin
        if (i < int'(setupCount)) pageTab[i] <= setupPfns[i*PFN_W +: PFN_W];
      end
    end else if (popStb) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  assign ptr       = ptrQ;
  assign mask      = maskQ;
  assign setupLog2 = kVal;

endmodule

// File: rtl/ring_idx_ctrl.sv
module ring_idx_ctrl
  import ring_idx_pkg::*;
#(
  parameter int MAX_PAGES = 4,
  parameter int IDX_W     = 32,
  parameter int CNT_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int LOG2_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cleanup,
  input  logic                   opValid,
  input  logic [1:0]             opCode,
  input  logic [1:0]             opRing,
  input  logic [CNT_W-1:0]       setupCount,
  input  logic [IDX_W-1:0]       hostProd,
  input  logic [IDX_W-1:0]       hostCons,
  input  logic [3:0][IDX_W-1:0]  ptrVec,
  input  logic [IDX_W-1:0]       msgMask,
  input  logic [3:0][ADDR_W-1:0] addrVec,
  input  logic [3:0][LOG2_W-1:0] log2Vec,
  output ring_strobe_t           stb,
  output logic                   rspValid,
  output logic                   rspEmpty,
  output logic                   rspSetupErr,
  output logic [ADDR_W-1:0]      rspAddr,
  output logic [IDX_W-1:0]       rspIdx,
  output logic [LOG2_W-1:0]      rspLog2
);

  opcode_e          op;
  logic             act, isPop, isSetup, blocked, countBad, popGo, setupGo, msgRoom;
  logic [IDX_W-1:0] curPtr, msgDiff, nextIdx;

  always_comb begin
    op       = opcode_e'(opCode);
    act      = opValid && (opRing != 2'd3) && (op != OP_NONE) && !cleanup;
    isPop    = act && (op == OP_POP);
    isSetup  = act && (op == OP_SETUP);
    curPtr   = ptrVec[opRing];
    msgDiff  = hostProd - hostCons;
    msgRoom  = {1'b0, msgDiff} < ({1'b0, msgMask} + 1'b1);
    case (opRing)
      2'd0:    blocked = (hostProd == curPtr);
      2'd2:    blocked = !msgRoom;
      default: blocked = 1'b0;
    endcase
    countBad = (setupCount == '0) || (int'(setupCount) > MAX_PAGES);
    popGo    = isPop && !blocked;
    setupGo  = isSetup && !countBad;
    for (int r = 0; r < NUM_RINGS; r++) begin
      stb.popStb[r]   = popGo   && (int'(opRing) == r);
      stb.setupStb[r] = setupGo && (int'(opRing) == r);
    end
    stb.clearAll = cleanup;
    if (popGo)        nextIdx = curPtr + 1'b1;
    else if (setupGo) nextIdx = '0;
    else              nextIdx = curPtr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid    <= 1'b0;
      rspEmpty    <= 1'b0;
      rspSetupErr <= 1'b0;
      rspAddr     <= '0;
      rspIdx      <= '0;
      rspLog2     <= '0;
    end else begin
      rspValid    <= act;
      rspEmpty    <= isPop && blocked;
      rspSetupErr <= isSetup && countBad;
      rspAddr     <= popGo ? addrVec[opRing] : '0;
      rspIdx      <= act ? nextIdx : '0;
      rspLog2     <= setupGo ? log2Vec[opRing] : '0;
    end
  end

endmodule

// File: rtl/ring_idx_mgr.sv
module ring_idx_mgr
  import ring_idx_pkg::*;
#(
  parameter int MAX_PAGES     = 4,
  parameter int PFN_W         = 20,
  parameter int PAGE_SHIFT    = 12,
  parameter int IDX_W         = 32,
  parameter int REQ_EPP_LOG2  = 5,
  parameter int REQ_DESC_LOG2 = 7,
  parameter int CMP_EPP_LOG2  = 7,
  parameter int CMP_DESC_LOG2 = 5,
  parameter int MSG_EPP_LOG2  = 5,
  parameter int MSG_DESC_LOG2 = 7,
  localparam int CNT_W  = $clog2(MAX_PAGES + 1),
  localparam int ADDR_W = PFN_W + PAGE_SHIFT,
  localparam int LOG2_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cleanup,
  input  logic                       opValid,
  input  logic [1:0]                 opCode,
  input  logic [1:0]                 opRing,
  input  logic [CNT_W-1:0]           setupCount,
  input  logic [MAX_PAGES*PFN_W-1:0] setupPfns,
  input  logic [IDX_W-1:0]           hostProd,
  input  logic [IDX_W-1:0]           hostCons,
  output logic                       rspValid,
  output logic                       rspEmpty,
  output logic                       rspSetupErr,
  output logic [ADDR_W-1:0]          rspAddr,
  output logic [IDX_W-1:0]           rspIdx,
  output logic [LOG2_W-1:0]          rspLog2
);

  ring_strobe_t            stb;
  logic [3:0][IDX_W-1:0]   ptrVec, maskVec;
  logic [3:0][ADDR_W-1:0]  addrVec;
  logic [3:0][LOG2_W-1:0]  log2Vec;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    localparam int EPP  = (g == 0) ? REQ_EPP_LOG2  : (g == 1) ? CMP_EPP_LOG2  : MSG_EPP_LOG2;
    localparam int DESC = (g == 0) ? REQ_DESC_LOG2 : (g == 1) ? CMP_DESC_LOG2 : MSG_DESC_LOG2;
    ring_page_path #(
      .MAX_PAGES(MAX_PAGES), .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W),
      .EPP_LOG2(EPP), .DESC_LOG2(DESC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W)
    ) u_path (
      .clk(clk), .rst_n(rst_n), .clearAll(stb.clearAll),
      .setupStb(stb.setupStb[g]), .popStb(stb.popStb[g]),
      .setupCount(setupCount), .setupPfns(setupPfns),
      .ptr(ptrVec[g]), .mask(maskVec[g]), .slotAddr(addrVec[g]), .setupLog2(log2Vec[g])
    );
  end

  assign ptrVec[3]  = '0;
  assign maskVec[3] = '0;
  assign addrVec[3] = '0;
  assign log2Vec[3] = '0;

  ring_idx_ctrl #(
    .MAX_PAGES(MAX_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cleanup(cleanup), .opValid(opValid), .opCode(opCode),
    .opRing(opRing), .setupCount(setupCount), .hostProd(hostProd), .hostCons(hostCons),
    .ptrVec(ptrVec), .msgMask(maskVec[2]), .addrVec(addrVec), .log2Vec(log2Vec),
    .stb(stb), .rspValid(rspValid), .rspEmpty(rspEmpty), .rspSetupErr(rspSetupErr),
    .rspAddr(rspAddr), .rspIdx(rspIdx), .rspLog2(rspLog2)
  );

endmodule

// File: rtl/ring_idx_checker.sv
module ring_idx_checker #(
  parameter int MAX_PAGES = 4,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 32,
  parameter int ADDR_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cleanup,
  input logic              opValid,
  input logic [1:0]        opCode,
  input logic [1:0]        opRing,
  input logic [CNT_W-1:0]  setupCount,
  input logic              rspValid,
  input logic              rspEmpty,
  input logic              rspSetupErr,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [IDX_W-1:0]  rspIdx
);

  AST_RSP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !cleanup && opRing != 2'd3 && opCode != 2'd3) |=> rspValid); // R11

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid || opRing == 2'd3 || opCode == 2'd3) |=> !rspValid); // R11

  AST_CLEANUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cleanup |=> !rspValid); // R10

  AST_EMPTY_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspEmpty) |-> (rspAddr == '0)); // R5

  AST_CMP_ALWAYS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !cleanup && opCode == 2'd0 && opRing == 2'd1) |=> (rspValid && !rspEmpty)); // R7

  AST_SETUP_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !cleanup && opCode == 2'd2 && opRing != 2'd3 && setupCount != '0
     && int'(setupCount) <= MAX_PAGES) |=> (rspIdx == '0 && !rspSetupErr)); // R2

  AST_BAD_COUNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !cleanup && opCode == 2'd2 && opRing != 2'd3
     && (setupCount == '0 || int'(setupCount) > MAX_PAGES)) |=> rspSetupErr); // R3

endmodule

bind ring_idx_mgr ring_idx_checker #(
  .MAX_PAGES(MAX_PAGES), .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cleanup(cleanup), .opValid(opValid), .opCode(opCode),
  .opRing(opRing), .setupCount(setupCount), .rspValid(rspValid), .rspEmpty(rspEmpty),
  .rspSetupErr(rspSetupErr), .rspAddr(rspAddr), .rspIdx(rspIdx)
);

// File: tb/tb_ring_idx_mgr.sv
module tb_ring_idx_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 4;

  typedef struct packed {
    logic [7:0]  tag;
    logic [1:0]  op;
    logic [1:0]  ring;
    logic [2:0]  cnt;
    logic [79:0] pfns;
    logic [31:0] prod;
    logic [31:0] cons;
    logic        eEmpty;
    logic        eErr;
    logic [31:0] eAddr;
    logic [31:0] eIdx;
    logic [5:0]  eLog2;
  } vec_t;

  localparam logic [79:0] PFA = {20'h00040, 20'h00030, 20'h00020, 20'h00010};
  localparam logic [79:0] PFB = {20'h0, 20'h0, 20'h00200, 20'h00100};
  localparam logic [79:0] PFC = {60'h0, 20'h00ABC};
  localparam logic [79:0] PF0 = '0;
  localparam int NV = 28;

  localparam vec_t VECS [NV] = '{
    '{8'd2, 2'd2, 2'd0, 3'd3, PFA, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd0, 6'd4}, // R2 req 3 pages
    '{8'd5, 2'd0, 2'd0, 3'd0, PF0, 32'd0, 32'd0, 1'b1, 1'b0, 32'h0,      32'd0, 6'd0}, // R5 empty
    '{8'd4, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b0, 1'b0, 32'h10000,  32'd1, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b0, 1'b0, 32'h10080,  32'd2, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b0, 1'b0, 32'h10100,  32'd3, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b0, 1'b0, 32'h10180,  32'd4, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b0, 1'b0, 32'h20000,  32'd5, 6'd0}, // R4 page cross
    '{8'd5, 2'd0, 2'd0, 3'd0, PF0, 32'd5, 32'd0, 1'b1, 1'b0, 32'h0,      32'd5, 6'd0}, // R5 caught up
    '{8'd9, 2'd1, 2'd0, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd5, 6'd0}, // R9
    '{8'd3, 2'd2, 2'd1, 3'd0, PFB, 32'd0, 32'd0, 1'b0, 1'b1, 32'h0,      32'd0, 6'd0}, // R3 count 0
    '{8'd3, 2'd2, 2'd1, 3'd5, PFB, 32'd0, 32'd0, 1'b0, 1'b1, 32'h0,      32'd0, 6'd0}, // R3 count 5
    '{8'd2, 2'd2, 2'd1, 3'd2, PFB, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd0, 6'd2}, // R2 cmp
    '{8'd7, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h100000, 32'd1, 6'd0}, // R7
    '{8'd4, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h100020, 32'd2, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h200000, 32'd3, 6'd0}, // R4
    '{8'd4, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h200020, 32'd4, 6'd0}, // R4
    '{8'd6, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h100000, 32'd5, 6'd0}, // R6 wrap
    '{8'd3, 2'd2, 2'd1, 3'd7, PFA, 32'd0, 32'd0, 1'b0, 1'b1, 32'h0,      32'd5, 6'd0}, // R3 count 7
    '{8'd3, 2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h100020, 32'd6, 6'd0}, // R3 state kept
    '{8'd9, 2'd1, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd6, 6'd0}, // R9
    '{8'd2, 2'd2, 2'd2, 3'd1, PFC, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd0, 6'd1}, // R2 msg
    '{8'd8, 2'd0, 2'd2, 3'd0, PF0, 32'h1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0, 32'd0, 6'd0}, // R8 full
    '{8'd8, 2'd0, 2'd2, 3'd0, PF0, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 32'hABC000, 32'd1, 6'd0}, // R8 room
    '{8'd8, 2'd0, 2'd2, 3'd0, PF0, 32'd5, 32'd5, 1'b0, 1'b0, 32'hABC080, 32'd2, 6'd0}, // R8
    '{8'd9, 2'd1, 2'd2, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd2, 6'd0}, // R9
    '{8'd2, 2'd2, 2'd0, 3'd4, PFA, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd0, 6'd4}, // R2 re-setup
    '{8'd6, 2'd0, 2'd0, 3'd0, PF0, 32'd3, 32'd0, 1'b0, 1'b0, 32'h10000,  32'd1, 6'd0}, // R6 restart
    '{8'd9, 2'd1, 2'd0, 3'd0, PF0, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0,      32'd1, 6'd0}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cleanup = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'd3;
  logic [1:0]  opRing = 2'd0;
  logic [2:0]  setupCount = '0;
  logic [79:0] setupPfns = '0;
  logic [31:0] hostProd = '0;
  logic [31:0] hostCons = '0;
  logic        rspValid, rspEmpty, rspSetupErr;
  logic [31:0] rspAddr, rspIdx;
  logic [5:0]  rspLog2;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_idx_mgr #(
    .MAX_PAGES(MAXP), .PFN_W(20), .PAGE_SHIFT(12), .IDX_W(32),
    .REQ_EPP_LOG2(2), .REQ_DESC_LOG2(7),
    .CMP_EPP_LOG2(1), .CMP_DESC_LOG2(5),
    .MSG_EPP_LOG2(1), .MSG_DESC_LOG2(7)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cleanup(cleanup), .opValid(opValid), .opCode(opCode),
    .opRing(opRing), .setupCount(setupCount), .setupPfns(setupPfns),
    .hostProd(hostProd), .hostCons(hostCons), .rspValid(rspValid), .rspEmpty(rspEmpty),
    .rspSetupErr(rspSetupErr), .rspAddr(rspAddr), .rspIdx(rspIdx), .rspLog2(rspLog2)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge; the response is sampled on the next falling edge
  task automatic runOp(input logic [1:0] op, input logic [1:0] ring, input logic [2:0] cnt,
                       input logic [79:0] pfns, input logic [31:0] prod, input logic [31:0] cons,
                       input logic clr);
    opValid = 1'b1; opCode = op; opRing = ring; setupCount = cnt;
    setupPfns = pfns; hostProd = prod; hostCons = cons; cleanup = clr;
    @(negedge clk);
    opValid = 1'b0; opCode = 2'd3; cleanup = 1'b0;
  endtask

  task automatic checkRsp(input string req, input logic v, input logic e, input logic er,
                          input logic [31:0] a, input logic [31:0] ix, input logic [5:0] lg);
    logic [31:0] packedAct, packedExp;
    packedAct = {23'd0, rspValid, rspEmpty, rspSetupErr, rspLog2};
    packedExp = {23'd0, v, e, er, lg};
    check(req, "valid/empty/err/log2", packedAct, packedExp);
    check(req, "addr", rspAddr, a);
    check(req, "idx", rspIdx, ix);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "rspValid after reset", 32'(rspValid), 32'd0);
    runOp(2'd1, 2'd0, 3'd0, PF0, 32'd0, 32'd0, 1'b0);
    checkRsp("R1", 1'b1, 1'b0, 1'b0, 32'h0, 32'd0, 6'd0);
    runOp(2'd1, 2'd2, 3'd0, PF0, 32'd0, 32'd0, 1'b0);
    checkRsp("R1", 1'b1, 1'b0, 1'b0, 32'h0, 32'd0, 6'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tagS;
      v = VECS[i];
      tagS = $sformatf("R%0d vec%0d", v.tag, i);
      runOp(v.op, v.ring, v.cnt, v.pfns, v.prod, v.cons, 1'b0);
      checkRsp(tagS, 1'b1, v.eEmpty, v.eErr, v.eAddr, v.eIdx, v.eLog2);
    end

    // R11: ring 3 and opcode 3 give no response and change nothing
    runOp(2'd0, 2'd3, 3'd0, PF0, 32'd9, 32'd0, 1'b0);
    check("R11", "no rsp ring 3", 32'(rspValid), 32'd0);
    runOp(2'd3, 2'd0, 3'd0, PF0, 32'd9, 32'd0, 1'b0);
    check("R11", "no rsp opcode 3", 32'(rspValid), 32'd0);
    runOp(2'd1, 2'd0, 3'd0, PF0, 32'd0, 32'd0, 1'b0);
    checkRsp("R11", 1'b1, 1'b0, 1'b0, 32'h0, 32'd1, 6'd0);

    // R10: cleanup swallows a concurrent pop and clears everything
    runOp(2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b1);
    check("R10", "no rsp under cleanup", 32'(rspValid), 32'd0);
    runOp(2'd1, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0);
    checkRsp("R10", 1'b1, 1'b0, 1'b0, 32'h0, 32'd0, 6'd0);
    runOp(2'd0, 2'd1, 3'd0, PF0, 32'd0, 32'd0, 1'b0);
    checkRsp("R10", 1'b1, 1'b0, 1'b0, 32'h0, 32'd1, 6'd0);
    runOp(2'd0, 2'd0, 3'd0, PF0, 32'd7, 32'd0, 1'b0);
    checkRsp("R10", 1'b1, 1'b0, 1'b0, 32'h0, 32'd1, 6'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule